// File: doc/BRIEF.md
# Clock Divider with Step-Down Ratio

This block derives a slower clock from its input clock. A parameter fixes the full ratio at divide-by-2 or divide-by-4. A step-down mode halves that ratio. In the divide-by-2 build, step-down passes the input clock straight through. In the divide-by-4 build, it yields a divide-by-2 clock. Two independent sources can request step-down: a lifecycle request and a software request. Scan mode overrides both and keeps the full ratio.

A request has no effect until the combined request has differed from the active ratio for a fixed number of input cycles. This filters short disturbances on the request lines. After that, the new ratio takes effect only at an edge of the output clock. No output high or low phase is ever shorter than a whole phase of either ratio. When step-down ends, the full ratio returns in whichever phase alignment the output happens to be in.

Top module: `clkdiv_step`

## Requirements
- R1: While reset is asserted, the output clock is low. The divider state is cleared.
- R2: The ratio parameter takes the value 2 (the default) or 4. Without step-down, the output period is that many input cycles, with one half high and one half low.
- R3: Step-down is requested when the lifecycle request or the software request is 1. Either source alone is enough.
- R4: While scan mode is 1, requests are ignored and the output keeps, or returns to, the full ratio.
- R5: A request change takes effect only after it has been present on WAIT consecutive input rising edges. A request shorter than WAIT cycles leaves the output at the full ratio.
- R6: In the divide-by-2 build, step-down makes the output equal to the input clock.
- R7: In the divide-by-4 build, step-down makes the output period two input cycles, one high and one low.
- R8: When the request is withdrawn, the full ratio of R2 returns, in either phase alignment.
- R9: Ratio changes take place at an output clock edge. Every high or low phase of the output lasts a whole phase of either the old or the new ratio, with no runt pulse.
- R10: The new ratio is in effect no later than WAIT+3 input cycles after the request changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| req_life_i | input | 1 | Step-down request from lifecycle control |
| req_sw_i | input | 1 | Step-down request from software |
| scan_mode_i | input | 1 | Scan mode; 1 suppresses step-down |
| clk_div_o | output | 1 | Divided (or stepped-down) clock |

## Verification
The hardest case to reach from the ports is the ratio switch itself. The point at which the filtered request lands relative to the output phase decides whether a runt phase could appear, and that point depends on the request's timing against an unknown output phase. The stimulus sweeps every request source with scan mode both on and off, and every short-pulse length below WAIT. It samples the output in both halves of every input cycle, so each transition is caught at a different phase. Each captured window is then checked for phase-run lengths and for periodicity, regardless of phase alignment.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic {
    RatioFull = 1'b0,
    RatioHalf = 1'b1
  } ratio_e;
endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/clkdiv_settle.sv
// Holds the accepted ratio; a differing request must persist WAIT edges.
module clkdiv_settle
  import clkdiv_pkg::*;
#(
  parameter int WAIT = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  output ratio_e held_o
);
  localparam int CW = (WAIT < 2) ? 1 : $clog2(WAIT + 1);
  localparam logic [CW-1:0] LastCnt = CW'(WAIT - 1);

  ratio_e        held_q, held_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          differs;

  assign differs = req_i != (held_q == RatioHalf);

  always_comb begin
    held_d = held_q;
    cnt_d  = cnt_q;
    if (!differs) begin
      cnt_d = '0;
    end else if (cnt_q == LastCnt) begin
      held_d = req_i ? RatioHalf : RatioFull;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= RatioFull;
      cnt_q  <= '0;
    end else begin
      held_q <= held_d;
      cnt_q  <= cnt_d;
    end
  end

  assign held_o = held_q;
endmodule

// File: rtl/clkdiv_core.sv
// Divider counter and boundary-aligned ratio switch, one variant per ratio.
module clkdiv_core
  import clkdiv_pkg::*;
#(
  parameter int DIV = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  ratio_e target_i,
  output logic   phase_o,
  output ratio_e mode_o,
  output logic   clk_o
);
  logic   div_q, div_d;
  ratio_e mode_q, mode_d;

  if (DIV == 4) begin : g_div4
    logic hc_q, hc_d;
    logic toggle_en;

    // Toggle every edge when stepped, every second edge otherwise.
    assign toggle_en = (mode_q == RatioHalf) || hc_q;

    always_comb begin
      div_d  = div_q;
      mode_d = mode_q;
      hc_d   = 1'b1;
      if (toggle_en) begin
        div_d  = ~div_q;
        mode_d = target_i;
        hc_d   = 1'b0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hc_q <= 1'b0;
      else         hc_q <= hc_d;
    end

    assign clk_o = div_q;
  end else begin : g_div2
    logic enter_en, leave_en;

    // Enter pass-through where the output would rise anyway; leave with output high.
    assign enter_en = (mode_q == RatioFull) && !div_q && (target_i == RatioHalf);
    assign leave_en = (mode_q == RatioHalf) && (target_i == RatioFull);

    always_comb begin
      div_d  = div_q;
      mode_d = mode_q;
      if (enter_en) begin
        div_d  = 1'b1;
        mode_d = RatioHalf;
      end else if (leave_en) begin
        div_d  = 1'b1;
        mode_d = RatioFull;
      end else if (mode_q == RatioFull) begin
        div_d  = ~div_q;
      end
    end

    assign clk_o = (mode_q == RatioHalf) ? clk_i : div_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= 1'b0;
      mode_q <= RatioFull;
    end else begin
      div_q  <= div_d;
      mode_q <= mode_d;
    end
  end

  assign phase_o = div_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/clkdiv_step.sv
module clkdiv_step
  import clkdiv_pkg::*;
#(
  parameter int DIV  = 2,
  parameter int WAIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_life_i,
  input  logic req_sw_i,
  input  logic scan_mode_i,
  output logic clk_div_o
);
  logic   rst_n_sync;
  logic   step_raw;
  ratio_e held_mode;
  ratio_e core_mode;
  logic   div_phase;

  assign step_raw = (req_life_i || req_sw_i) && !scan_mode_i;

  clkdiv_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  clkdiv_settle #(.WAIT(WAIT)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .req_i  (step_raw),
    .held_o (held_mode)
  );

  clkdiv_core #(.DIV(DIV)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_sync),
    .target_i (held_mode),
    .phase_o  (div_phase),
    .mode_o   (core_mode),
    .clk_o    (clk_div_o)
  );
endmodule

// File: rtl/clkdiv_step_chk.sv
module clkdiv_step_chk
  import clkdiv_pkg::*;
#(
  parameter int DIV  = 2,
  parameter int WAIT = 4
) (
  input logic   clk_i,
  input logic   rst_n,
  input logic   req_life_i,
  input logic   req_sw_i,
  input logic   scan_mode_i,
  input ratio_e held_mode,
  input ratio_e core_mode,
  input logic   div_phase,
  input logic   clk_div_o
);
  localparam int CW = $clog2(WAIT + 2);
  logic [CW-1:0] diff_run;
  logic          req_now;

  assign req_now = (req_life_i || req_sw_i) && !scan_mode_i;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) diff_run <= '0;
    else if (req_now == (held_mode == RatioHalf)) diff_run <= '0;
    else if (diff_run != CW'(WAIT)) diff_run <= diff_run + 1'b1;
  end

  // R1: output low while the divider is held in reset
  always @(negedge clk_i) begin
    if (rst_n === 1'b0) assert_reset_low_R1: assert (clk_div_o == 1'b0);
  end

  // R5: accepted ratio moves only after WAIT differing edges
  assert_settle_held_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(held_mode) |-> diff_run == CW'(WAIT));

  // R4: step-down never accepted from a cycle with scan mode on
  assert_scan_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(held_mode == RatioHalf) |-> $past(!scan_mode_i));

  if (DIV == 4) begin : g_chk4
    // R9: ratio switches only together with an output edge
    assert_edge_switch_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
      !$stable(core_mode) |-> !$stable(div_phase));
    // R2: in full ratio each output phase spans two input cycles
    assert_full_half_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
      (!$stable(div_phase) && core_mode == RatioFull) |=> $stable(div_phase));
  end else begin : g_chk2
    // R9: pass-through entered only where the divided clock rises
    assert_enter_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
      $rose(core_mode == RatioHalf) |-> (div_phase && !$past(div_phase)));
    // R9: pass-through left with the output held high for a whole phase
    assert_leave_high_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
      $fell(core_mode == RatioHalf) |-> div_phase);
  end
endmodule

bind clkdiv_step clkdiv_step_chk #(.DIV(DIV), .WAIT(WAIT)) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n_sync),
  .req_life_i  (req_life_i),
  .req_sw_i    (req_sw_i),
  .scan_mode_i (scan_mode_i),
  .held_mode   (held_mode),
  .core_mode   (core_mode),
  .div_phase   (div_phase),
  .clk_div_o   (clk_div_o)
);

// File: tb/sim_clkdiv_step.sv
`timescale 1ns/1ps
module sim_clkdiv_step;
  localparam int WAIT = 4;
  localparam int TRANS = WAIT + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic life = 1'b0;
  logic sw = 1'b0;
  logic scan = 1'b0;
  logic o2, o4;
  logic [63:0] sa, sb;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clkdiv_step #(.DIV(2), .WAIT(WAIT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_life_i(life), .req_sw_i(sw),
    .scan_mode_i(scan), .clk_div_o(o2));

  clkdiv_step #(.DIV(4), .WAIT(WAIT)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_life_i(life), .req_sw_i(sw),
    .scan_mode_i(scan), .clk_div_o(o4));

  // two samples per input cycle: high half, then low half
  task automatic capture(input int n);
    sa = '0; sb = '0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      sa[2*i] = o2; sb[2*i] = o4;
      @(negedge clk); #2;
      sa[2*i+1] = o2; sb[2*i+1] = o4;
    end
  endtask

  // periodic with p half-samples, h of them high, any phase
  task automatic check_period(input string tag, input bit which, input int n,
                              input int p, input int h);
    logic [63:0] v;
    int ones;
    bit ok;
    v = which ? sb : sa;
    ok = 1;
    ones = 0;
    for (int i = 0; i < 2*n - p; i++) if (v[i] != v[i+p]) ok = 0;
    for (int i = 0; i < p; i++) ones += v[i];
    if (ones != h) ok = 0;
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s div%0d: samples %b ones %0d, expected period %0d high %0d",
               tag, which ? 4 : 2, v, ones, p, h);
    end
  endtask

  // interior run lengths must be a or b half-samples
  task automatic check_runs(input string tag, input bit which, input int n,
                            input int a, input int b);
    logic [63:0] v;
    int run;
    int first;
    int bad;
    v = which ? sb : sa;
    run = 1; first = 1; bad = 0;
    for (int i = 1; i < 2*n; i++) begin
      if (v[i] == v[i-1]) run++;
      else begin
        if (!first && run != a && run != b) bad = run;
        first = 0;
        run = 1;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s div%0d: run of %0d in %b, expected runs %0d or %0d",
               tag, which ? 4 : 2, bad, v, a, b);
    end
  endtask

  task automatic expect_full(input string tag);
    capture(16);
    check_period(tag, 1'b0, 16, 4, 2);
    check_period(tag, 1'b1, 16, 8, 4);
  endtask

  task automatic expect_trans(input string tag);
    capture(TRANS);
    check_runs(tag, 1'b0, TRANS, 1, 2);
    check_runs(tag, 1'b1, TRANS, 2, 4);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: output low throughout reset
    capture(6);
    checks++;
    if (sa[11:0] != 12'h0 || sb[11:0] != 12'h0) begin
      errors++;
      $display("FAIL R1: reset samples %h/%h, expected 000/000", sa[11:0], sb[11:0]);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: full ratio after reset
    expect_full("R2 full ratio");

    // R3/R4/R6/R7/R8/R9/R10: sweep request sources and scan mode
    for (int src = 1; src <= 3; src++) begin
      for (int sc = 0; sc < 2; sc++) begin
        life = src[0]; sw = src[1]; scan = sc[0];
        expect_trans("R9 entering");
        capture(16);
        if (sc != 0) begin
          check_period("R4 scan masks", 1'b0, 16, 4, 2);
          check_period("R4 scan masks", 1'b1, 16, 8, 4);
        end else begin
          check_period("R3 R6 R10 pass-through", 1'b0, 16, 2, 1);
          check_period("R3 R7 R10 halved", 1'b1, 16, 4, 2);
        end
        life = 1'b0; sw = 1'b0; scan = 1'b0;
        expect_trans("R9 leaving");
        expect_full("R8 R10 full returns");
      end
    end

    // R4: scan raised while stepped down restores full ratio
    sw = 1'b1;
    expect_trans("R9 entering");
    capture(16);
    check_period("R6 stepped", 1'b0, 16, 2, 1);
    check_period("R7 stepped", 1'b1, 16, 4, 2);
    scan = 1'b1;
    expect_trans("R9 scan leave");
    expect_full("R4 scan override");
    sw = 1'b0; scan = 1'b0;
    repeat (2) @(negedge clk);

    // R5: pulses shorter than WAIT are ignored
    for (int len = 1; len < WAIT; len++) begin
      life = 1'b1;
      repeat (len) @(negedge clk);
      life = 1'b0;
      expect_full("R5 short pulse ignored");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule